// File: doc/BRIEF.md
# I/O Domain Wake and Calibration Sequencer

This block controls a power-gated I/O domain. It wakes the domain from sleep and brings it to a calibrated state in which traffic may flow, and it puts the domain back to sleep on request. On a wake request it turns on the domain's power-switch groups one at a time, with a programmable gap between groups, so that the inrush current is spread out. It then waits for a programmable guard time and only after that releases the isolation controls.

Once isolation is released, the block takes one of two paths. If the retained calibration settings are marked valid, it issues a single restore strobe and goes straight to ready. If they are not valid, it runs five calibration steps in a fixed order, each through its own start/done handshake:

1. Reference settling.
2. Impedance calibration.
3. Receiver offset cancellation.
4. Equalization training.
5. Duty-cycle correction and clock phase alignment.

If any step does not answer within a time limit, the block enters a sticky error state and stays not ready.

Sleep entry runs the wake order in reverse. Traffic is stopped at once, isolation is asserted, a retention save strobe is issued, and the switch groups are turned off from the highest group down.

Top module: `pws_wake_seq`

## Requirements
- R1: After reset: all switch enables are 0, `iso_en`=1, and `ready`, `traffic_en`, `cal_err`, `ret_restore`, `ret_save` and `cal_start` are all 0.
- R2: On wake, switch groups turn on in ascending index order. Each step adds exactly one group (bit g of `sw_en` is group g), and successive groups turn on `gap`+1 cycles apart.
- R3: `iso_en` stays 1 while any switch group is off. It falls exactly `guard`+2 cycles after the last group turns on.
- R4: Without valid retention, calibration runs the five steps in order, bit 0 of `cal_start` through bit 4. The order is reference settling, impedance, receiver offset, equalization, then duty-cycle and phase alignment. Exactly one start bit is high, and it is held until the matching `cal_done` bit is seen.
- R5: `traffic_en` and `ready` are 0 whenever a calibration step is in progress. Both are 1 once the chain or the restore has finished and `wake_req` is still 1.
- R6: If `ret_valid` is 1 when isolation is released, `ret_restore` pulses for exactly one cycle, no calibration step starts, and `ready` rises on the next cycle.
- R7: If a step sees no done within `CAL_TMO` cycles, `cal_err` rises. It stays 1, with `ready` and `traffic_en` held at 0 and the switches left unchanged, regardless of `wake_req`, until reset.
- R8: When `wake_req` falls in the ready state, the sleep sequence runs as follows:
  - `traffic_en` falls in the same cycle.
  - `iso_en` rises next.
  - `ret_save` pulses after that.
  - Only then do the switch groups turn off, highest index first, one at a time, `gap`+1 cycles apart, ending with `iso_en`=1 and `ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_req | input | 1 | 1 requests the awake domain, 0 requests sleep |
| gap | input | CW | Extra cycles between switch-group steps |
| guard | input | CW | Guard cycles after the last switch group before isolation release |
| ret_valid | input | 1 | Retained calibration settings are valid |
| cal_done | input | NCAL | Per-step completion from the calibration engines |
| sw_en | output | NGRP | Power-switch group enables |
| iso_en | output | 1 | Isolation active (clamp signals into the domain) |
| ret_restore | output | 1 | One-cycle strobe to restore retained settings |
| ret_save | output | 1 | One-cycle strobe to save settings before power-off |
| cal_start | output | NCAL | Per-step start, one-hot, held until done |
| ready | output | 1 | Domain powered and calibrated |
| traffic_en | output | 1 | Data transmission permitted |
| cal_err | output | 1 | A calibration step timed out (sticky) |

## Verification
The hardest state to reach is a calibration step that never completes. The timeout fires only after the full ramp, the guard and the earlier steps have passed, and the engine must then hold back a single done bit. The bench reaches it with a behavioural calibration-engine model that can be told to stall on the third step. After that it drops `wake_req` to show that the error state holds the domain as it is. The exact switch-group spacing and the guard-to-release distance are swept over every gap and guard value from 0 to 3, and every combination is run with retention both valid and invalid.

// File: rtl/pws_pkg.sv
// Package: shared state encoding for the wake/calibration sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package pws_pkg;

    typedef enum logic [3:0] {
        ST_SLEEP,
        ST_RAMP_UP,
        ST_GUARD,
        ST_RESTORE,
        ST_CAL,
        ST_READY,
        ST_ISO_ON,
        ST_SAVE,
        ST_RAMP_DN,
        ST_ERR
    } pws_state_e;

endpackage

// File: rtl/pws_switch_ramp.sv
// Module: progressive power-switch ramp.
// Turns switch groups on (ascending) or off (descending) one per step, with
// step spacing of gap+1 cycles. The first step lands on the first cycle the
// command is seen. Assumes go_up and go_dn are never both high.
module pws_switch_ramp #(
    parameter int NGRP = 4,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_up,
    input  logic            go_dn,
    input  logic [CW-1:0]   gap,
    output logic [NGRP-1:0] sw_en,
    output logic            all_on,
    output logic            all_off
);
    localparam int NW = $clog2(NGRP + 1);
    localparam logic [NW-1:0] FULL = NW'(NGRP);

    logic [NW-1:0] n_on;
    logic [CW-1:0] tmr;

    // Step the count of enabled groups, paced by the gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_on <= '0;
            tmr  <= '0;
        end else if (go_up && n_on != FULL) begin
            if (tmr == '0) begin
                n_on <= n_on + 1'b1;
                tmr  <= gap;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end else if (go_dn && n_on != '0) begin
            if (tmr == '0) begin
                n_on <= n_on - 1'b1;
                tmr  <= gap;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end else begin
            tmr <= '0;
        end
    end

    // Thermometer decode: group g is on when more than g groups are counted.
    for (genvar g = 0; g < NGRP; g++) begin : g_therm
        assign sw_en[g] = (n_on > NW'(g));
    end

    assign all_on  = (n_on == FULL);
    assign all_off = (n_on == '0);

endmodule

// File: rtl/pws_cal_chain.sv
// Module: ordered calibration chain with per-step timeout.
// While run is high, it raises one start bit at a time (step 0 first) and
// holds it until the matching done bit arrives. It flags timed_out when a
// step waits TMO cycles. Dropping run clears all state. Assumes NCAL >= 2.
module pws_cal_chain #(
    parameter int NCAL = 5,
    parameter int TMO  = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [NCAL-1:0] cal_done,
    output logic [NCAL-1:0] cal_start,
    output logic            finished,
    output logic            timed_out
);
    localparam int IW = $clog2(NCAL);
    localparam int TW = $clog2(TMO + 1);
    localparam logic [IW-1:0] LAST = IW'(NCAL - 1);

    logic [IW-1:0] idx;
    logic [TW-1:0] tmr;
    logic          hit;

    assign hit = |(cal_done & cal_start);

    // Advance through steps on done; count idle cycles toward the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            idx       <= '0;
            tmr       <= '0;
            finished  <= 1'b0;
            timed_out <= 1'b0;
        end else if (!finished && !timed_out) begin
            if (hit) begin
                tmr <= '0;
                if (idx == LAST) finished <= 1'b1;
                else             idx      <= idx + 1'b1;
            end else if (tmr == TW'(TMO - 1)) begin
                timed_out <= 1'b1;
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    // One-hot start decode for the active step.
    for (genvar k = 0; k < NCAL; k++) begin : g_start
        assign cal_start[k] = run && !finished && !timed_out && (idx == IW'(k));
    end

endmodule

// File: rtl/pws_wake_seq.sv
// Module: top-level wake/sleep sequencer for a power-gated I/O domain.
// Wake order: switch ramp, guard time, isolation release, then either a
// retention restore or the full calibration chain, then ready.
// Sleep order: stop traffic, assert isolation, save retention, ramp switches down.
// A calibration timeout parks the block in a sticky error state until reset.
// Assumes gap and guard are held stable during a sequence.
module pws_wake_seq #(
    parameter int NGRP    = 4,
    parameter int NCAL    = 5,
    parameter int CW      = 8,
    parameter int CAL_TMO = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wake_req,
    input  logic [CW-1:0]   gap,
    input  logic [CW-1:0]   guard,
    input  logic            ret_valid,
    input  logic [NCAL-1:0] cal_done,
    output logic [NGRP-1:0] sw_en,
    output logic            iso_en,
    output logic            ret_restore,
    output logic            ret_save,
    output logic [NCAL-1:0] cal_start,
    output logic            ready,
    output logic            traffic_en,
    output logic            cal_err
);
    import pws_pkg::*;

    pws_state_e    state, state_nx;
    logic [CW-1:0] gcnt;
    logic          all_on, all_off, cal_fin, cal_to;

    pws_switch_ramp #(.NGRP(NGRP), .CW(CW)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_up   (state == ST_RAMP_UP),
        .go_dn   (state == ST_RAMP_DN),
        .gap     (gap),
        .sw_en   (sw_en),
        .all_on  (all_on),
        .all_off (all_off)
    );

    pws_cal_chain #(.NCAL(NCAL), .TMO(CAL_TMO)) u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state == ST_CAL),
        .cal_done  (cal_done),
        .cal_start (cal_start),
        .finished  (cal_fin),
        .timed_out (cal_to)
    );

    // Next-state selection for the wake and sleep sequences.
    always_comb begin
        state_nx = state;
        case (state)
            ST_SLEEP:   if (wake_req) state_nx = ST_RAMP_UP;
            ST_RAMP_UP: if (all_on)   state_nx = ST_GUARD;
            ST_GUARD:   if (gcnt == guard)
                            state_nx = ret_valid ? ST_RESTORE : ST_CAL;
            ST_RESTORE: state_nx = ST_READY;
            ST_CAL:     if (cal_to)       state_nx = ST_ERR;
                        else if (cal_fin) state_nx = ST_READY;
            ST_READY:   if (!wake_req) state_nx = ST_ISO_ON;
            ST_ISO_ON:  state_nx = ST_SAVE;
            ST_SAVE:    state_nx = ST_RAMP_DN;
            ST_RAMP_DN: if (all_off) state_nx = ST_SLEEP;
            ST_ERR:     state_nx = ST_ERR;
            default:    state_nx = ST_SLEEP;
        endcase
    end

    // State register and guard-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SLEEP;
            gcnt  <= '0;
        end else begin
            state <= state_nx;
            gcnt  <= (state == ST_GUARD) ? gcnt + 1'b1 : '0;
        end
    end

    // Output decode from state.
    assign iso_en      = !(state == ST_RESTORE || state == ST_CAL || state == ST_READY);
    assign ret_restore = (state == ST_RESTORE);
    assign ret_save    = (state == ST_SAVE);
    assign ready       = (state == ST_READY);
    assign traffic_en  = ready && wake_req;
    assign cal_err     = (state == ST_ERR);

endmodule

// File: rtl/pws_wake_seq_chk.sv
// Checker: temporal properties of the sequencer's ports, bound to the top.
module pws_wake_seq_chk #(
    parameter int NGRP = 4,
    parameter int NCAL = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NGRP-1:0] sw_en,
    input logic            iso_en,
    input logic            ret_restore,
    input logic            ret_save,
    input logic [NCAL-1:0] cal_start,
    input logic            ready,
    input logic            traffic_en,
    input logic            cal_err
);
    // R2
    sw_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_en ^ $past(sw_en)) <= 1);
    // R2
    sw_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en & (sw_en + NGRP'(1))) == '0);
    // R3
    iso_until_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en != '1) |-> iso_en);
    // R4
    cal_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cal_start));
    // R5
    no_traffic_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_start != '0) |-> (!traffic_en && !ready));
    // R6
    restore_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_restore |=> (ready && !ret_restore));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |=> (cal_err && !ready && $stable(sw_en)));
    // R8
    save_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_save |-> (iso_en && sw_en == '1));
endmodule

bind pws_wake_seq pws_wake_seq_chk #(.NGRP(NGRP), .NCAL(NCAL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_en       (sw_en),
    .iso_en      (iso_en),
    .ret_restore (ret_restore),
    .ret_save    (ret_save),
    .cal_start   (cal_start),
    .ready       (ready),
    .traffic_en  (traffic_en),
    .cal_err     (cal_err)
);

// File: tb/pws_wake_seq_bench.sv
// Bench: sweeps gap, guard and retention validity over a small configuration,
// with a behavioural calibration engine that can stall on a chosen step.
module pws_wake_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NG  = 4;
    localparam int NC  = 5;
    localparam int CWB = 4;
    localparam int TMO = 20;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           wake_req;
    logic [CWB-1:0] gap, guard;
    logic           ret_valid;
    logic [NC-1:0]  cal_done;
    logic [NG-1:0]  sw_en;
    logic           iso_en, ret_restore, ret_save, ready, traffic_en, cal_err;
    logic [NC-1:0]  cal_start;

    int checks = 0;
    int failures = 0;
    int eng_lat = 1;
    int eng_hang = -1;
    int eng_cnt = 0;
    logic [NC-1:0] eng_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pws_wake_seq #(.NGRP(NG), .NCAL(NC), .CW(CWB), .CAL_TMO(TMO)) u_pws_wake_seq (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .gap(gap), .guard(guard),
        .ret_valid(ret_valid), .cal_done(cal_done), .sw_en(sw_en), .iso_en(iso_en),
        .ret_restore(ret_restore), .ret_save(ret_save), .cal_start(cal_start),
        .ready(ready), .traffic_en(traffic_en), .cal_err(cal_err)
    );

    // Calibration engine model: answers a held start after eng_lat cycles.
    always @(negedge clk) begin
        cal_done = '0;
        if (cal_start != '0) begin
            if (cal_start == eng_prev) eng_cnt++;
            else eng_cnt = 0;
            if (eng_cnt == eng_lat && !(eng_hang >= 0 && cal_start == NC'(1 << eng_hang)))
                cal_done = cal_start;
        end else begin
            eng_cnt = 0;
        end
        eng_prev = cal_start;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wake_req = 1'b0; gap = '0; guard = '0; ret_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sw_en == '0, "R1 sw_en", int'(sw_en), 0);
        chk(iso_en == 1'b1, "R1 iso_en", int'(iso_en), 1);
        chk(!ready && !traffic_en, "R1 ready/traffic", int'(ready) + int'(traffic_en), 0);
        chk(!cal_err && !ret_restore && !ret_save, "R1 err/strobes",
            int'(cal_err) + int'(ret_restore) + int'(ret_save), 0);
        chk(cal_start == '0, "R1 cal_start", int'(cal_start), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_wake(input int g, input int gd, input bit rv, input int lat);
        int t = 0, tlast = 0, nexp = 0, ncal = 0, nrest = 0;
        bit bad_traffic = 0;
        logic [NG-1:0] psw;
        logic piso;
        logic [NC-1:0] pst;
        @(negedge clk);
        gap = CWB'(g); guard = CWB'(gd); ret_valid = rv; eng_lat = lat; wake_req = 1'b1;
        psw = sw_en; piso = iso_en; pst = cal_start;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            t++;
            if (sw_en != psw) begin
                // R2 ascending one-at-a-time with gap+1 spacing
                chk(sw_en == (psw | NG'(1 << nexp)), "R2 order", int'(sw_en), int'(psw | NG'(1 << nexp)));
                if (nexp > 0) chk(t - tlast == g + 1, "R2 spacing", t - tlast, g + 1);
                tlast = t;
                nexp++;
            end
            if (piso && !iso_en) begin
                // R3 release only after all groups plus guard
                chk(nexp == NG, "R3 groups on at release", nexp, NG);
                chk(t - tlast == gd + 2, "R3 guard distance", t - tlast, gd + 2);
            end
            if (cal_start != '0 && cal_start != pst) begin
                // R4 step order
                chk(cal_start == NC'(1 << ncal), "R4 step order", int'(cal_start), 1 << ncal);
                ncal++;
            end
            if (cal_start != '0 && (traffic_en || ready)) bad_traffic = 1;
            if (ret_restore) nrest++;
            psw = sw_en; piso = iso_en; pst = cal_start;
            if (ready) break;
        end
        chk(!bad_traffic, "R5 no traffic during calibration", int'(bad_traffic), 0);
        chk(ready && traffic_en, "R5 ready and traffic after wake", int'(ready) + int'(traffic_en), 2);
        if (rv) begin
            chk(ncal == 0, "R6 no calibration steps", ncal, 0);
            chk(nrest == 1, "R6 single restore strobe", nrest, 1);
        end else begin
            chk(ncal == NC, "R4 all steps run", ncal, NC);
            chk(nrest == 0, "R4 no restore", nrest, 0);
        end
    endtask

    task automatic run_sleep(input int g);
        int t = 0, tiso = -1, tsave = -1, toff = -1, tlast = 0, nk = 0;
        logic [NG-1:0] psw;
        @(negedge clk);
        gap = CWB'(g);
        wake_req = 1'b0;
        #1;
        chk(traffic_en == 1'b0, "R8 traffic stops at once", int'(traffic_en), 0);
        psw = sw_en;
        for (int i = 0; i < 500 && nk < NG; i++) begin
            @(negedge clk);
            t++;
            if (iso_en && tiso < 0) tiso = t;
            if (ret_save && tsave < 0) tsave = t;
            if (sw_en != psw) begin
                chk(sw_en == (psw & ~NG'(1 << (NG - 1 - nk))), "R8 descending order",
                    int'(sw_en), int'(psw & ~NG'(1 << (NG - 1 - nk))));
                if (nk == 0) toff = t;
                else chk(t - tlast == g + 1, "R8 off spacing", t - tlast, g + 1);
                tlast = t;
                nk++;
            end
            psw = sw_en;
        end
        chk(tiso >= 0 && tsave > tiso && toff > tsave, "R8 iso, save, off order", tsave, tiso + 1);
        @(negedge clk);
        chk(sw_en == '0 && iso_en && !ready, "R8 asleep", int'(sw_en), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        for (int g = 0; g < 4; g++)
            for (int gd = 0; gd < 4; gd++)
                for (int rv = 0; rv < 2; rv++) begin
                    run_wake(g, gd, rv[0], (g + gd) % 3 + 1);
                    run_sleep(g);
                end

        // R7 timeout on the third step
        do_reset();
        eng_hang = 2;
        @(negedge clk);
        gap = CWB'(1); guard = CWB'(1); ret_valid = 1'b0; eng_lat = 2; wake_req = 1'b1;
        for (int i = 0; i < 400 && !cal_err; i++) @(negedge clk);
        chk(cal_err == 1'b1, "R7 error raised", int'(cal_err), 1);
        chk(!ready && !traffic_en, "R7 not ready", int'(ready) + int'(traffic_en), 0);
        wake_req = 1'b0;
        repeat (30) @(negedge clk);
        chk(cal_err == 1'b1, "R7 error sticky", int'(cal_err), 1);
        chk(sw_en == '1, "R7 switches unchanged", int'(sw_en), (1 << NG) - 1);
        chk(!ready, "R7 still not ready", int'(ready), 0);
        eng_hang = -1;
        do_reset();
        chk(cal_err == 1'b0, "R1 error cleared by reset", int'(cal_err), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule